// File: doc/BRIEF.md
# Branch Target Prediction Buffer

This block predicts the direction and destination of control-transfer instructions for a five-stage 32-bit pipeline. The decode stage presents the PC of the instruction it holds. In the same cycle the block reports whether the buffer knows that PC (hit), whether it expects a taken transfer, and the address it expects control to move to. Fetch can then be redirected one stage earlier than execute-stage resolution would allow. Both conditional branches and unconditional jumps are recorded.

Each entry is a direct-mapped slot. The slot is chosen by PC bits [IDX_W+1:2]. The slot stores a valid flag, the remaining upper PC bits as a tag, a word-aligned target, and a 2-bit saturating confidence counter. The execute stage writes back each resolved instruction: its PC, whether it was taken, and where it went. Taken instructions that miss claim their slot. Instructions that hit train the counter up or down. The default configuration uses a 10-bit index and a 20-bit tag (PC[31:12]).

Top module: `btb_predictor`

## Requirements
- R1: After reset every lookup misses (hit_o = 0), whatever the PC.
- R2: A lookup hits only when the slot at PC[IDX_W+1:2] is valid and its stored tag equals PC[ADDR_W-1:IDX_W+2]. A PC with the same index but a different tag misses.
- R3: On a miss, taken_o is 0 and target_o is 0.
- R4: A taken update that misses allocates its slot. The slot takes the tag and target and becomes valid, and its counter is set to weakly taken (2), so the next lookup of that PC hits and predicts taken.
- R5: A not-taken update that misses changes nothing.
- R6: A taken update that hits increments the counter, which saturates at 3 (strongly taken).
- R7: A not-taken update that hits decrements the counter, which saturates at 0. taken_o is 1 on a hit exactly when counter bit 1 is set (counter 2 or 3).
- R8: A taken update that hits rewrites the stored target. A not-taken update that hits keeps the old target. target_o always has bits [1:0] = 0.
- R9: PC bits [1:0] take no part in indexing or tag compare, on either port.
- R10: When a lookup and an update hit the same slot in one cycle, the lookup reports the contents from before the update. The new contents show from the next cycle.
- R11: A taken update whose tag differs from a valid slot's tag replaces that slot, and the previous PC then misses.
- R12: With no update, the outputs for an unchanged lookup PC stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all valid flags |
| lkp_pc_i | input | ADDR_W | Decode-stage PC to look up |
| hit_o | output | 1 | Slot valid and tag matches |
| taken_o | output | 1 | Predicted taken |
| target_o | output | ADDR_W | Predicted target, 0 on a miss |
| upd_valid_i | input | 1 | Resolved instruction present this cycle |
| upd_pc_i | input | ADDR_W | PC of the resolved instruction |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| upd_target_i | input | ADDR_W | Resolved target address |

## Verification
The hardest case to reach is the same-cycle collision. A lookup and a counter-changing update must strike one slot together, and the prediction must flip as a result. The stimulus first trains a slot to weakly taken. It then drives the lookup PC and a not-taken update for that PC in the same half-cycle. The bench samples once before the clock edge, expecting the old taken prediction, and once after it, expecting not-taken. Counter saturation is covered by applying every 4-bit outcome sequence, one per slot of a 16-slot build, and comparing each step against an arithmetic model.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_e;
endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  localparam int TAG_W = ADDR_W - IDX_W - 2
) (
  input  logic [ADDR_W-1:2] word_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  assign idx_o = word_i[IDX_W+1:2];
  assign tag_o = word_i[ADDR_W-1:IDX_W+2];
endmodule

// File: rtl/btb_ctr_sat.sv
module btb_ctr_sat
  import btb_pkg::*;
(
  input  ctr_e ctr_i,
  input  logic up_i,
  output ctr_e ctr_o
);
  always_comb begin
    ctr_o = ctr_i;
    if (up_i) begin
      if (ctr_i != CTR_ST) ctr_o = ctr_e'(ctr_i + 2'd1);
    end else begin
      if (ctr_i != CTR_SNT) ctr_o = ctr_e'(ctr_i - 2'd1);
    end
  end
endmodule

// File: rtl/btb_array.sv
module btb_array
  import btb_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TAG_W = 20,
  parameter int TGT_W = 30,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  // two combinational read ports
  input  logic [IDX_W-1:0] ra_idx_i,
  output logic             ra_vld_o,
  output logic [TAG_W-1:0] ra_tag_o,
  output logic [TGT_W-1:0] ra_tgt_o,
  output ctr_e             ra_ctr_o,
  input  logic [IDX_W-1:0] rb_idx_i,
  output logic             rb_vld_o,
  output logic [TAG_W-1:0] rb_tag_o,
  output logic [TGT_W-1:0] rb_tgt_o,
  output ctr_e             rb_ctr_o,
  // write port
  input  logic             we_i,
  input  logic [IDX_W-1:0] w_idx_i,
  input  logic [TAG_W-1:0] w_tag_i,
  input  logic [TGT_W-1:0] w_tgt_i,
  input  ctr_e             w_ctr_i
);
  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TGT_W-1:0] tgt_q [DEPTH];
  ctr_e             ctr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= '0;
    else if (we_i) vld_q[w_idx_i] <= 1'b1;
  end

  // payload needs no reset: masked by valid
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[w_idx_i] <= w_tag_i;
      tgt_q[w_idx_i] <= w_tgt_i;
      ctr_q[w_idx_i] <= w_ctr_i;
    end
  end

  assign ra_vld_o = vld_q[ra_idx_i];
  assign ra_tag_o = tag_q[ra_idx_i];
  assign ra_tgt_o = tgt_q[ra_idx_i];
  assign ra_ctr_o = ctr_q[ra_idx_i];
  assign rb_vld_o = vld_q[rb_idx_i];
  assign rb_tag_o = tag_q[rb_idx_i];
  assign rb_tgt_o = tgt_q[rb_idx_i];
  assign rb_ctr_o = ctr_q[rb_idx_i];
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lkp_pc_i,
  output logic              hit_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i
);
  localparam int TAG_W = ADDR_W - IDX_W - 2;
  localparam int TGT_W = ADDR_W - 2;

  logic unused_lsb;
  assign unused_lsb = ^{lkp_pc_i[1:0], upd_pc_i[1:0], upd_target_i[1:0]};

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  btb_pc_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_split (
    .word_i(lkp_pc_i[ADDR_W-1:2]), .idx_o(lk_idx), .tag_o(lk_tag));
  btb_pc_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_up_split (
    .word_i(upd_pc_i[ADDR_W-1:2]), .idx_o(up_idx), .tag_o(up_tag));

  logic             lk_vld, up_vld;
  logic [TAG_W-1:0] lk_stag, up_stag;
  logic [TGT_W-1:0] lk_tgt, up_tgt;
  ctr_e             lk_ctr, up_ctr, up_ctr_nxt, w_ctr;
  logic             we;
  logic [TGT_W-1:0] w_tgt;

  btb_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_array (
    .clk_i, .rst_ni,
    .ra_idx_i(lk_idx), .ra_vld_o(lk_vld), .ra_tag_o(lk_stag),
    .ra_tgt_o(lk_tgt), .ra_ctr_o(lk_ctr),
    .rb_idx_i(up_idx), .rb_vld_o(up_vld), .rb_tag_o(up_stag),
    .rb_tgt_o(up_tgt), .rb_ctr_o(up_ctr),
    .we_i(we), .w_idx_i(up_idx), .w_tag_i(up_tag),
    .w_tgt_i(w_tgt), .w_ctr_i(w_ctr));

  btb_ctr_sat u_sat (.ctr_i(up_ctr), .up_i(upd_taken_i), .ctr_o(up_ctr_nxt));

  logic lk_hit, up_hit;
  assign lk_hit = lk_vld && (lk_stag == lk_tag);
  assign up_hit = up_vld && (up_stag == up_tag);

  // lookup: old contents, write lands at the edge
  assign hit_o    = lk_hit;
  assign taken_o  = lk_hit && lk_ctr[1];
  assign target_o = lk_hit ? {lk_tgt, 2'b00} : '0;

  // update: train on hit, claim slot on taken miss
  assign we    = upd_valid_i && (up_hit || upd_taken_i);
  assign w_ctr = up_hit ? up_ctr_nxt : CTR_WT;
  assign w_tgt = (up_hit && !upd_taken_i) ? up_tgt : upd_target_i[ADDR_W-1:2];
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] lkp_pc_i,
  input logic              hit_o,
  input logic              taken_o,
  input logic [ADDR_W-1:0] target_o,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_pc_i,
  input logic              upd_taken_i,
  input logic [ADDR_W-1:0] upd_target_i
);
  logic unused_chk;
  assign unused_chk = ^{upd_target_i[1:0], IDX_W[0]};

  // R1
  reset_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !hit_o);

  // R3
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!taken_o && target_o == '0));

  // R4
  alloc_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |=>
      ((lkp_pc_i[ADDR_W-1:2] != $past(upd_pc_i[ADDR_W-1:2])) || hit_o));

  // R8
  tgt_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |=>
      ((lkp_pc_i[ADDR_W-1:2] != $past(upd_pc_i[ADDR_W-1:2])) ||
       (target_o[ADDR_W-1:2] == $past(upd_target_i[ADDR_W-1:2]))));

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> ($stable(lkp_pc_i) ->
      ($stable(hit_o) && $stable(taken_o) && $stable(target_o))));
endmodule

bind btb_predictor btb_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lkp_pc_i(lkp_pc_i), .hit_o(hit_o),
  .taken_o(taken_o), .target_o(target_o), .upd_valid_i(upd_valid_i),
  .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i), .upd_target_i(upd_target_i));

// File: tb/sim_btb_predictor.sv
module sim_btb_predictor;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 4;
  localparam int N      = 1 << IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] lkp_pc = '0, upd_pc = '0, upd_target = '0, target;
  logic upd_valid = 1'b0, upd_taken = 1'b0, hit, taken;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  btb_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lkp_pc_i(lkp_pc), .hit_o(hit),
    .taken_o(taken), .target_o(target), .upd_valid_i(upd_valid),
    .upd_pc_i(upd_pc), .upd_taken_i(upd_taken), .upd_target_i(upd_target));

  // reference model
  bit          m_v   [N];
  logic [31:0] m_tag [N];
  logic [31:0] m_tgt [N];
  int          m_ctr [N];

  function automatic int idx_of(logic [31:0] pc); return int'(pc[IDX_W+1:2]); endfunction
  function automatic logic [31:0] tag_of(logic [31:0] pc); return pc >> (IDX_W + 2); endfunction

  function automatic void model_upd(logic [31:0] pc, logic tk, logic [31:0] tg);
    int i = idx_of(pc);
    bit h = m_v[i] && (m_tag[i] == tag_of(pc));
    if (h) begin
      m_ctr[i] = tk ? ((m_ctr[i] == 3) ? 3 : m_ctr[i] + 1)
                    : ((m_ctr[i] == 0) ? 0 : m_ctr[i] - 1);
      if (tk) m_tgt[i] = tg & 32'hFFFF_FFFC;
    end else if (tk) begin
      m_v[i] = 1'b1; m_tag[i] = tag_of(pc);
      m_tgt[i] = tg & 32'hFFFF_FFFC; m_ctr[i] = 2;
    end
  endfunction

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, a, e);
    end
  endtask

  task automatic exp_out(input string r, input logic [31:0] pc);
    int i = idx_of(pc);
    bit h = m_v[i] && (m_tag[i] == tag_of(pc));
    chk({r, " hit"}, {31'd0, hit}, {31'd0, h});
    chk({r, " taken"}, {31'd0, taken}, {31'd0, h && (m_ctr[i] >= 2)});
    chk({r, " target"}, target, h ? m_tgt[i] : 32'd0);
  endtask

  task automatic look(input string r, input logic [31:0] pc);
    @(negedge clk); lkp_pc = pc; #1;
    exp_out(r, pc);
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg;
    @(posedge clk); model_upd(pc, tk, tg); #1;
    upd_valid = 1'b0;
  endtask

  function automatic logic [31:0] pc_at(logic [31:0] tag, int i);
    return (tag << (IDX_W + 2)) | (32'(i) << 2);
  endfunction

  localparam logic [31:0] TAG_A = 32'h0012_345;
  localparam logic [31:0] TAG_B = 32'h00AB_CDE;

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_ctr[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R3: empty after reset
    for (int i = 0; i < N; i++) look("R1 R3 reset", pc_at(TAG_A, i));

    // R5: not-taken misses leave nothing behind
    for (int i = 0; i < N; i++) upd(pc_at(TAG_A, i), 1'b0, 32'h4000 + 32'(i*4));
    for (int i = 0; i < N; i++) look("R5 nt-miss", pc_at(TAG_A, i));

    // R4: allocate every slot
    for (int i = 0; i < N; i++) upd(pc_at(TAG_A, i), 1'b1, 32'h8000_0000 + 32'(i*16));
    for (int i = 0; i < N; i++) look("R4 alloc", pc_at(TAG_A, i));

    // R6 R7 R8: every 4-step outcome pattern, one per slot
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 4; k++) begin
        upd(pc_at(TAG_A, i), i[k], 32'h1000_0003 + 32'(i*256 + k*4));
        look("R6 R7 R8 train", pc_at(TAG_A, i));
      end

    // R6 R7: saturation at both ends on slot 0
    for (int k = 0; k < 5; k++) begin upd(pc_at(TAG_A, 0), 1'b1, 32'h2000); look("R6 sat-hi", pc_at(TAG_A, 0)); end
    for (int k = 0; k < 6; k++) begin upd(pc_at(TAG_A, 0), 1'b0, 32'h3000); look("R7 sat-lo", pc_at(TAG_A, 0)); end

    // R2: same index, other tag misses
    for (int i = 0; i < N; i++) look("R2 alias", pc_at(TAG_B, i));

    // R11: taken conflicting update replaces the slot
    upd(pc_at(TAG_B, 3), 1'b1, 32'h7777_0000);
    look("R11 new", pc_at(TAG_B, 3));
    look("R11 old", pc_at(TAG_A, 3));

    // R9: low PC bits ignored
    for (int b = 1; b < 4; b++) look("R9 lsb", pc_at(TAG_B, 3) | 32'(b));
    upd(pc_at(TAG_A, 5) | 32'd3, 1'b1, 32'h5555_5554);
    look("R9 upd-lsb", pc_at(TAG_A, 5));

    // R10: collision, prepare slot 7 at counter 2
    upd(pc_at(TAG_B, 7), 1'b1, 32'h0000_7700);
    @(negedge clk);
    lkp_pc = pc_at(TAG_B, 7);
    upd_valid = 1'b1; upd_pc = pc_at(TAG_B, 7); upd_taken = 1'b0; upd_target = '0;
    #1;
    chk("R10 before taken", {31'd0, taken}, 32'd1);
    @(posedge clk); model_upd(pc_at(TAG_B, 7), 1'b0, '0); #1;
    upd_valid = 1'b0;
    chk("R10 after taken", {31'd0, taken}, 32'd0);
    exp_out("R10 after", pc_at(TAG_B, 7));

    // R12: idle cycles do not disturb a lookup
    lkp_pc = pc_at(TAG_B, 3);
    repeat (4) @(negedge clk);
    #1; exp_out("R12 idle", pc_at(TAG_B, 3));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule